// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block commits the architectural side effects of taking a trap. When a trap request arrives with its cause word, exception PC and faulting address, it decides within the same cycle whether machine mode or supervisor mode handles the trap. On the next clock edge it writes the program counter, the cause, exception PC and bad-address registers of the chosen mode, the status stack bits and the current privilege level.

The most significant bit of the cause word marks an interrupt. That bit picks which delegation mask is consulted: the interrupt mask when it is set, the exception mask otherwise. The remaining bits form the index into that mask. Delegation to supervisor mode is honoured only when the hart runs at user or supervisor level. A trap taken while in machine mode always stays in machine mode.

The surrounding core supplies the current status and privilege, and it reads back the registered results. A load-reservation flag is kept here so that every trap entry can cancel it.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After synchronous reset the outputs are: `pc_o` = RESET_PC, `priv_o` = 3 (machine), `status_o` = 0, all six cause/epc/bad-address outputs = 0, `resv_o` = 0, `to_s_o` = 0.
- R2: With cause bit XLEN-1 set, the delegation bit is read from `ideleg_i` at the index given by the lower cause bits. With bit XLEN-1 clear, it is read from `edeleg_i`.
- R3: Privilege encoding is U=0, S=1, M=3. A trap taken at privilege M goes to machine mode regardless of any delegation bit.
- R4: A cause index (cause with bit XLEN-1 removed) of XLEN or more always goes to machine mode. It never aliases a lower mask bit.
- R5: Supervisor entry loads `pc_o` from `stvec_i` and writes `scause_o` with the full cause including bit XLEN-1. It also writes `sepc_o` with `epc_i` and `sbad_o` with `badaddr_i`. The three machine trap registers keep their values.
- R6: Status layout is [7:6] MPP, [5] SPP, [4] MPIE, [3] SPIE, [2] MIE, [1] SIE, [0] UIE. On supervisor entry, SPIE takes the enable bit of the current privilege (UIE for U, SIE for S) and SPP takes the current privilege's low bit. SIE becomes 0 and `priv_o` becomes 1. The other fields are copied from `status_i`.
- R7: Machine entry loads `pc_o` with the constant MTVEC and writes `mcause_o`, `mepc_o` and `mbad_o` in the same way. The three supervisor trap registers keep their values.
- R8: On machine entry, MPIE takes the enable bit of the current privilege (UIE, SIE or MIE for U, S, M) and MPP takes the current privilege. MIE becomes 0 and `priv_o` becomes 3. The other fields are copied from `status_i`.
- R9: `resv_set_i` sets `resv_o` on the next edge. A trap clears it on the next edge, and a trap wins over a set in the same cycle.
- R10: Without `trap_i`, `pc_o`, `priv_o`, `status_o` and all trap registers hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | 1 | Trap request, one cycle |
| cause_i | input | XLEN | Trap cause, MSB = interrupt |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| status_i | input | 8 | Current status stack bits |
| priv_i | input | 2 | Current privilege |
| resv_set_i | input | 1 | Establish a load reservation |
| pc_o | output | XLEN | Next program counter |
| priv_o | output | 2 | Privilege after entry |
| status_o | output | 8 | Status after entry |
| to_s_o | output | 1 | Last trap went to supervisor |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| sbad_o | output | XLEN | Supervisor bad address |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mbad_o | output | XLEN | Machine bad address |
| resv_o | output | 1 | Load reservation valid |

## Verification
The bench builds the block with its defaults: XLEN = 32, RESET_PC = 0x1000 and MTVEC = 0x100. With a 32-bit word, a cause index of 40 is reachable while the exception mask has bit 8 set. This exposes any index that is truncated to five bits instead of range-checked. The chosen masks let one cause code be delegated through one mask and not the other, so selecting the wrong mask changes the target mode.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
    logic       uie;
  } stat_t;
endpackage

// File: rtl/trap_deleg_decide.sv
module trap_deleg_decide #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] edeleg_i,
  input  logic [XLEN-1:0] ideleg_i,
  input  logic [1:0]      priv_i,
  output logic            to_s_o
);
  localparam int IW = $clog2(XLEN);

  logic [XLEN-2:0] idx;
  logic [XLEN-1:0] mask;
  logic            in_range;
  logic            dbit;

  assign idx      = cause_i[XLEN-2:0];
  assign mask     = cause_i[XLEN-1] ? ideleg_i : edeleg_i;
  assign in_range = idx < (XLEN-1)'(XLEN);
  assign dbit     = in_range ? mask[idx[IW-1:0]] : 1'b0;
  assign to_s_o   = (priv_i <= trap_pkg::PRIV_S) && dbit;
endmodule

// File: rtl/trap_status_update.sv
module trap_status_update (
  input  logic [7:0] status_i,
  input  logic [1:0] priv_i,
  input  logic       to_s_i,
  output logic [7:0] status_o,
  output logic [1:0] priv_o
);
  import trap_pkg::*;

  stat_t cur;
  stat_t nxt;
  logic  cur_en;

  assign cur = stat_t'(status_i);

  always_comb begin
    unique case (priv_i)
      PRIV_U:  cur_en = cur.uie;
      PRIV_S:  cur_en = cur.sie;
      PRIV_M:  cur_en = cur.mie;
      default: cur_en = 1'b0;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (to_s_i) begin
      nxt.spie = cur_en;
      nxt.spp  = priv_i[0];
      nxt.sie  = 1'b0;
      priv_o   = PRIV_S;
    end else begin
      nxt.mpie = cur_en;
      nxt.mpp  = priv_i;
      nxt.mie  = 1'b0;
      priv_o   = PRIV_M;
    end
  end

  assign status_o = nxt;
endmodule

// File: rtl/trap_mode_regs.sv
module trap_mode_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] bad_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      epc_o   <= '0;
      bad_o   <= '0;
    end else if (we_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      bad_o   <= bad_i;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
  parameter int          XLEN     = 32,
  parameter int unsigned RESET_PC = 32'h0000_1000,
  parameter int unsigned MTVEC    = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic [XLEN-1:0] edeleg_i,
  input  logic [XLEN-1:0] ideleg_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [7:0]      status_i,
  input  logic [1:0]      priv_i,
  input  logic            resv_set_i,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [7:0]      status_o,
  output logic            to_s_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbad_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbad_o,
  output logic            resv_o
);
  localparam int NMODE = 2;  // index 0 = supervisor, 1 = machine

  logic            to_s;
  logic [7:0]      stat_nxt;
  logic [1:0]      priv_nxt;
  logic [XLEN-1:0] vec_pc;
  logic [XLEN-1:0] cause_q [NMODE];
  logic [XLEN-1:0] epc_q   [NMODE];
  logic [XLEN-1:0] bad_q   [NMODE];

  trap_deleg_decide #(.XLEN(XLEN)) u_decide (
    .cause_i  (cause_i),
    .edeleg_i (edeleg_i),
    .ideleg_i (ideleg_i),
    .priv_i   (priv_i),
    .to_s_o   (to_s)
  );

  trap_status_update u_stat (
    .status_i (status_i),
    .priv_i   (priv_i),
    .to_s_i   (to_s),
    .status_o (stat_nxt),
    .priv_o   (priv_nxt)
  );

  for (genvar g = 0; g < NMODE; g++) begin : g_mode
    logic sel;
    assign sel = (g == 0) ? to_s : !to_s;
    trap_mode_regs #(.XLEN(XLEN)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we_i    (trap_i && sel),
      .cause_i (cause_i),
      .epc_i   (epc_i),
      .bad_i   (badaddr_i),
      .cause_o (cause_q[g]),
      .epc_o   (epc_q[g]),
      .bad_o   (bad_q[g])
    );
  end

  assign vec_pc = to_s ? stvec_i : XLEN'(MTVEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o     <= XLEN'(RESET_PC);
      priv_o   <= trap_pkg::PRIV_M;
      status_o <= '0;
      to_s_o   <= 1'b0;
      resv_o   <= 1'b0;
    end else begin
      if (trap_i) begin
        pc_o     <= vec_pc;
        priv_o   <= priv_nxt;
        status_o <= stat_nxt;
        to_s_o   <= to_s;
        resv_o   <= 1'b0;
      end else if (resv_set_i) begin
        resv_o   <= 1'b1;
      end
    end
  end

  assign scause_o = cause_q[0];
  assign sepc_o   = epc_q[0];
  assign sbad_o   = bad_q[0];
  assign mcause_o = cause_q[1];
  assign mepc_o   = epc_q[1];
  assign mbad_o   = bad_q[1];
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_i,
  input logic [XLEN-1:0] cause_i,
  input logic [XLEN-1:0] stvec_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [7:0]      status_o,
  input logic            resv_o
);
  logic big_idx;
  assign big_idx = cause_i[XLEN-2:0] >= (XLEN-1)'(XLEN);

  a_r3_m_stays_m: assert property (@(posedge clk) disable iff (rst)
    (trap_i && priv_i == 2'd3) |=> (priv_o == 2'd3));

  a_r4_big_index_machine: assert property (@(posedge clk) disable iff (rst)
    (trap_i && big_idx) |=> (priv_o == 2'd3));

  a_r5_s_vector: assert property (@(posedge clk) disable iff (rst)
    trap_i |=> ((priv_o != 2'd1) || (pc_o == $past(stvec_i))));

  a_r8_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    trap_i |=> (priv_o == 2'd1 ? !status_o[1] : !status_o[2]));

  a_r9_resv_cancel: assert property (@(posedge clk) disable iff (rst)
    trap_i |=> !resv_o);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !trap_i |=> ($stable(pc_o) && $stable(priv_o) && $stable(status_o)));
endmodule

bind trap_entry_ctrl trap_entry_checker #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trap_i   (trap_i),
  .cause_i  (cause_i),
  .stvec_i  (stvec_i),
  .priv_i   (priv_i),
  .pc_o     (pc_o),
  .priv_o   (priv_o),
  .status_o (status_o),
  .resv_o   (resv_o)
);

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;
  localparam int XLEN = 32;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] MVEC   = 32'h0000_0100;
  localparam logic [31:0] EDELEG = 32'h0000_2104; // bits 2, 8, 13
  localparam logic [31:0] IDELEG = 32'h0000_0022; // bits 1, 5
  localparam logic [31:0] SVEC   = 32'h0000_8000;

  typedef struct packed {
    logic [1:0]  priv;
    logic [7:0]  stat;
    logic [31:0] cause;
    logic        exp_s;
    logic [7:0]  exp_stat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h07, 32'd8,          1'b1, 8'h0D}, // R2 exception deleg, from U
    '{2'd1, 8'h02, 32'd2,          1'b1, 8'h28}, // R6 from S
    '{2'd3, 8'h04, 32'd2,          1'b0, 8'hD0}, // R3 M stays M
    '{2'd1, 8'h00, 32'h8000_0005,  1'b1, 8'h20}, // R2 interrupt deleg
    '{2'd1, 8'h02, 32'h8000_0008,  1'b0, 8'h52}, // R2 interrupt mask used
    '{2'd0, 8'h01, 32'd5,          1'b0, 8'h11}, // R2 exception mask used
    '{2'd0, 8'h00, 32'h8000_0001,  1'b1, 8'h00}, // R6
    '{2'd1, 8'hFF, 32'd13,         1'b1, 8'hFD}, // R6 other fields kept
    '{2'd0, 8'h00, 32'd40,         1'b0, 8'h00}, // R4 index >= XLEN
    '{2'd3, 8'h00, 32'd8,          1'b0, 8'hC0}  // R3 / R8
  };

  logic clk = 1'b0;
  logic rst;
  logic trap_i, resv_set_i;
  logic [31:0] cause_i, epc_i, badaddr_i, edeleg_i, ideleg_i, stvec_i;
  logic [7:0]  status_i;
  logic [1:0]  priv_i;
  logic [31:0] pc_o, scause_o, sepc_o, sbad_o, mcause_o, mepc_o, mbad_o;
  logic [1:0]  priv_o;
  logic [7:0]  status_o;
  logic        to_s_o, resv_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN)) i_trap_entry_ctrl (
    .clk(clk), .rst(rst), .trap_i(trap_i), .cause_i(cause_i), .epc_i(epc_i),
    .badaddr_i(badaddr_i), .edeleg_i(edeleg_i), .ideleg_i(ideleg_i),
    .stvec_i(stvec_i), .status_i(status_i), .priv_i(priv_i),
    .resv_set_i(resv_set_i), .pc_o(pc_o), .priv_o(priv_o),
    .status_o(status_o), .to_s_o(to_s_o), .scause_o(scause_o),
    .sepc_o(sepc_o), .sbad_o(sbad_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
    .mbad_o(mbad_o), .resv_o(resv_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [31:0] e_sc, e_se, e_sb, e_mc, e_me, e_mb;
    rst = 1'b1; trap_i = 0; resv_set_i = 0;
    cause_i = 0; epc_i = 0; badaddr_i = 0; status_i = 0; priv_i = 0;
    edeleg_i = EDELEG; ideleg_i = IDELEG; stvec_i = SVEC;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_o, RST_PC);
    chk("R1 priv", {30'd0, priv_o}, 32'd3);
    chk("R1 status", {24'd0, status_o}, 32'd0);
    chk("R1 scause", scause_o, 32'd0);
    chk("R1 mcause", mcause_o, 32'd0);
    chk("R1 resv", {31'd0, resv_o}, 32'd0);
    e_sc = 0; e_se = 0; e_sb = 0; e_mc = 0; e_me = 0; e_mb = 0;

    for (int i = 0; i < NV; i++) begin
      priv_i = VECS[i].priv;
      status_i = VECS[i].stat;
      cause_i = VECS[i].cause;
      epc_i = 32'h0000_4000 + 32'(i * 4);
      badaddr_i = 32'h000A_0000 + 32'(i);
      trap_i = 1'b1;
      @(negedge clk);
      trap_i = 1'b0;
      if (VECS[i].exp_s) begin
        e_sc = cause_i; e_se = epc_i; e_sb = badaddr_i;
        chk("R5 pc", pc_o, SVEC);
        chk("R6 priv", {30'd0, priv_o}, 32'd1);
      end else begin
        e_mc = cause_i; e_me = epc_i; e_mb = badaddr_i;
        chk("R7 pc", pc_o, MVEC);
        chk("R8 priv", {30'd0, priv_o}, 32'd3);
      end
      chk("R2 target", {31'd0, to_s_o}, {31'd0, VECS[i].exp_s});
      chk(VECS[i].exp_s ? "R6 status" : "R8 status", {24'd0, status_o}, {24'd0, VECS[i].exp_stat});
      chk("R5 scause", scause_o, e_sc);
      chk("R5 sepc", sepc_o, e_se);
      chk("R5 sbad", sbad_o, e_sb);
      chk("R7 mcause", mcause_o, e_mc);
      chk("R7 mepc", mepc_o, e_me);
      chk("R7 mbad", mbad_o, e_mb);
    end

    // R10: inputs change without a trap
    cause_i = 32'd2; priv_i = 2'd1; status_i = 8'hAA; stvec_i = 32'h0000_9000;
    epc_i = 32'hDEAD_0000; badaddr_i = 32'hBEEF_0000;
    repeat (3) @(negedge clk);
    chk("R10 pc", pc_o, MVEC);
    chk("R10 priv", {30'd0, priv_o}, 32'd3);
    chk("R10 status", {24'd0, status_o}, 32'h0000_00C0);
    chk("R10 mepc", mepc_o, e_me);
    chk("R10 sepc", sepc_o, e_se);

    // R9 reservation
    resv_set_i = 1'b1;
    @(negedge clk);
    resv_set_i = 1'b0;
    chk("R9 set", {31'd0, resv_o}, 32'd1);
    resv_set_i = 1'b1; trap_i = 1'b1; priv_i = 2'd3; cause_i = 32'd3;
    @(negedge clk);
    resv_set_i = 1'b0; trap_i = 1'b0;
    chk("R9 trap wins", {31'd0, resv_o}, 32'd0);
    resv_set_i = 1'b1;
    @(negedge clk);
    resv_set_i = 1'b0;
    chk("R9 set again", {31'd0, resv_o}, 32'd1);
    trap_i = 1'b1;
    @(negedge clk);
    trap_i = 1'b0;
    chk("R9 trap cancel", {31'd0, resv_o}, 32'd0);

    // R1 reset again after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 pc after reset", pc_o, RST_PC);
    chk("R1 mepc after reset", mepc_o, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule